// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block carries out transfers for a bank of DMA channels whose base address, base count, mode byte and mask bit are loaded over a simple configuration port. A client raises a request naming a channel and how many elements it would like moved. The sequencer decodes that channel's mode byte. It moves no more elements than the channel still has left, at one element per clock. For each element it issues one memory strobe, which is a write, a read or a verify, together with the element address. It steps the channel's current address and decrements its current count.

When the run ends, a one-cycle done pulse carries the number of elements moved. If the channel's count has reached zero, the controller status records terminal count and drops the channel's pending soft request. With autoinitialisation selected, the current registers are then reloaded from the base registers. A mode with no executable behaviour (demand, block or cascade), or the illegal transfer type, is flagged on the done pulse and moves nothing. Channels are grouped four to a controller, and each controller has one status byte. Reading that byte clears its terminal-count half.

Top module: `dma_xfer_seq`

## Requirements
- R1: The mode byte is decoded as follows: bits 7:6 are the operating mode, and only 01 (single) executes. Bit 5 set steps the address downward. Bit 4 set enables autoinitialisation. Bits 3:2 are the transfer type.
- R2: Transfer type 0 gives one `mem_vfy` strobe per element, type 1 one `mem_wr`, and type 2 one `mem_rd`. Type 3 moves nothing and raises `flag_err` on the done pulse. At most one strobe is high in any cycle.
- R3: A request to a channel whose mask bit is set gives a done pulse with a count of 0. It produces no strobe and changes neither the current address nor the current count.
- R4: The number of elements moved is the smaller of the channel's current count and `req_len`. One element is moved per clock, and `busy` is high from the cycle after acceptance through the done cycle.
- R5: Channels below NCH/2 move 1-byte elements and the others move 2-byte elements, which is shown on `mem_wide`. The current address changes by the element size after each element and wraps modulo 2^AW.
- R6: At the end of a run where the current count is zero, the channel's terminal-count status bit is set and its soft-request status bit is cleared.
- R7: At terminal count with autoinitialisation enabled, the current address and count are reloaded from the base registers. Without it, both keep their final values, and a later request moves 0 elements and sets terminal count again.
- R8: Operating mode 00 or 10 raises `flag_unsup`, and mode 11 raises `flag_err`. Either way nothing is moved.
- R9: `stat_q` shows the controller chosen by `stat_ctl` as {soft-request bits of its four channels, terminal-count bits}. `stat_rd` clears that controller's terminal-count bits at the clock edge, and a terminal count set at the same edge takes priority.
- R10: `cfg_sel` selects the register written. 0 writes the base and current address, 1 writes the base and current count, 2 writes the mode byte, and 3 writes the mask from `cfg_data[0]` and, if `cfg_data[1]` is set, sets the soft-request bit. Writes are ignored while `busy` is high.
- R11: `done` is high for exactly one cycle, directly after the last strobe, or in the first busy cycle when nothing is moved. `done_cnt`, `flag_unsup` and `flag_err` are zero outside that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CHW | Channel written |
| cfg_sel | input | 2 | Register select (R10) |
| cfg_data | input | AW | Write data |
| req_valid | input | 1 | Transfer request, taken when not busy |
| req_ch | input | CHW | Requested channel |
| req_len | input | CW | Requested element count |
| busy | output | 1 | Request in progress |
| done | output | 1 | End-of-request pulse |
| done_cnt | output | CW | Elements moved, valid with done |
| flag_unsup | output | 1 | Demand or block mode requested |
| flag_err | output | 1 | Cascade mode or illegal type requested |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_vfy | output | 1 | Verify strobe, no data movement |
| mem_addr | output | AW | Element address |
| mem_wide | output | 1 | Element is two bytes |
| stat_rd | input | 1 | Status read, clears terminal-count bits |
| stat_ctl | input | CTLW | Controller whose status is shown |
| stat_q | output | 8 | Status byte |

## Verification
On every cycle the assertions check the following. Strobes are mutually exclusive and appear only inside a busy run. Successive element addresses differ by exactly the element size in the chosen direction. The done pulse lasts a single cycle and never reports more than was requested. Flagged requests move nothing. Other behaviours involve state that lives across requests, so only the bench's scenarios can show them. These are the min-of-counts result, terminal-count status and its clearing on read, autoinit reload against no reload, masked requests leaving the channel untouched, and writes dropped while busy. The bench shows them by comparing every cycle against its behavioural model.

// File: rtl/dma_xfer_seq.sv
`timescale 1ns/1ps
module dma_xfer_seq #(
  parameter int NCH = 8,
  parameter int AW  = 24,
  parameter int CW  = 16,
  localparam int CHW  = $clog2(NCH),
  localparam int NCTL = NCH / 4,
  localparam int CTLW = (NCTL > 1) ? $clog2(NCTL) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [CHW-1:0]  cfg_ch,
  input  logic [1:0]      cfg_sel,
  input  logic [AW-1:0]   cfg_data,
  input  logic            req_valid,
  input  logic [CHW-1:0]  req_ch,
  input  logic [CW-1:0]   req_len,
  output logic            busy,
  output logic            done,
  output logic [CW-1:0]   done_cnt,
  output logic            flag_unsup,
  output logic            flag_err,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            mem_vfy,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_wide,
  input  logic            stat_rd,
  input  logic [CTLW-1:0] stat_ctl,
  output logic [7:0]      stat_q
);
  localparam int HALF = NCH / 2;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;
  st_t st;

  logic [AW-1:0]  base_a [NCH];
  logic [AW-1:0]  cur_a  [NCH];
  logic [CW-1:0]  base_c [NCH];
  logic [CW-1:0]  cur_c  [NCH];
  logic [7:0]     mode_r [NCH];
  logic [NCH-1:0] mask_r, tc_r, rq_r;

  logic [CHW-1:0] ch_q;
  logic [CW-1:0]  rem_q, moved_q, len_q;
  logic [1:0]     typ_q;
  logic           ok_q, uns_q, err_q, dec_q, auto_q;

  wire [7:0]    m_acc   = mode_r[req_ch];
  wire [1:0]    opm_acc = m_acc[7:6];
  wire [1:0]    typ_acc = m_acc[3:2];
  wire [CW-1:0] n_acc   = (cur_c[req_ch] < req_len) ? cur_c[req_ch] : req_len;
  wire          accept  = req_valid && (st == S_IDLE);
  wire          msk_acc = mask_r[req_ch];
  wire          uns_acc = !msk_acc && (opm_acc == 2'b00 || opm_acc == 2'b10);
  wire          err_acc = !msk_acc && !uns_acc && (opm_acc == 2'b11 || typ_acc == 2'b11);
  wire          go_acc  = !msk_acc && !uns_acc && !err_acc;
  wire          run     = (st == S_RUN);
  wire          wide_q  = (ch_q >= CHW'(HALF));
  wire [AW-1:0] step    = wide_q ? AW'(2) : AW'(1);
  wire          fin_tc  = (st == S_FIN) && ok_q && (cur_c[ch_q] == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      for (int i = 0; i < NCH; i++) begin
        base_a[i] <= '0; cur_a[i] <= '0;
        base_c[i] <= '0; cur_c[i] <= '0;
        mode_r[i] <= '0;
      end
      mask_r <= '1; tc_r <= '0; rq_r <= '0;
      ch_q <= '0; rem_q <= '0; moved_q <= '0; len_q <= '0;
      typ_q <= '0; ok_q <= 1'b0; uns_q <= 1'b0; err_q <= 1'b0;
      dec_q <= 1'b0; auto_q <= 1'b0;
    end else begin
      if (stat_rd)
        for (int i = 0; i < NCH; i++)
          if (CTLW'(i / 4) == stat_ctl) tc_r[i] <= 1'b0;

      if (cfg_we && st == S_IDLE) begin
        case (cfg_sel)
          2'd0: begin base_a[cfg_ch] <= cfg_data; cur_a[cfg_ch] <= cfg_data; end
          2'd1: begin base_c[cfg_ch] <= cfg_data[CW-1:0]; cur_c[cfg_ch] <= cfg_data[CW-1:0]; end
          2'd2: mode_r[cfg_ch] <= cfg_data[7:0];
          default: begin
            mask_r[cfg_ch] <= cfg_data[0];
            if (cfg_data[1]) rq_r[cfg_ch] <= 1'b1;
          end
        endcase
      end

      case (st)
        S_IDLE: if (accept) begin
          ch_q    <= req_ch;
          len_q   <= req_len;
          typ_q   <= typ_acc;
          dec_q   <= m_acc[5];
          auto_q  <= m_acc[4];
          ok_q    <= go_acc;
          uns_q   <= uns_acc;
          err_q   <= err_acc;
          rem_q   <= go_acc ? n_acc : '0;
          moved_q <= go_acc ? n_acc : '0;
          st      <= (go_acc && n_acc != '0) ? S_RUN : S_FIN;
        end
        S_RUN: begin
          cur_a[ch_q] <= dec_q ? cur_a[ch_q] - step : cur_a[ch_q] + step;
          cur_c[ch_q] <= cur_c[ch_q] - 1'b1;
          rem_q       <= rem_q - 1'b1;
          if (rem_q == CW'(1)) st <= S_FIN;
        end
        default: begin
          st <= S_IDLE;
          if (fin_tc) begin
            tc_r[ch_q] <= 1'b1;
            rq_r[ch_q] <= 1'b0;
            if (auto_q) begin
              cur_a[ch_q] <= base_a[ch_q];
              cur_c[ch_q] <= base_c[ch_q];
            end
          end
        end
      endcase
    end
  end

  assign busy       = (st != S_IDLE);
  assign done       = (st == S_FIN);
  assign done_cnt   = done ? moved_q : '0;
  assign flag_unsup = done && uns_q;
  assign flag_err   = done && err_q;
  assign mem_vfy    = run && typ_q == 2'd0;
  assign mem_wr     = run && typ_q == 2'd1;
  assign mem_rd     = run && typ_q == 2'd2;
  assign mem_addr   = run ? cur_a[ch_q] : '0;
  assign mem_wide   = run && wide_q;
  assign stat_q     = {rq_r[stat_ctl*4 +: 4], tc_r[stat_ctl*4 +: 4]};

  wire strobe = mem_rd || mem_wr || mem_vfy;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr, mem_vfy})); // R2
  AST_STROBE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (busy && !done)); // R4
  AST_MOVED_LE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_cnt <= len_q)); // R4
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && $past(strobe)) |->
      (mem_addr == (dec_q ? $past(mem_addr) - step : $past(mem_addr) + step))); // R5
  AST_FLAG_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_unsup || flag_err) |-> (done_cnt == '0)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
endmodule

// File: tb/dma_xfer_seq_bench.sv
`timescale 1ns/1ps
module dma_xfer_seq_bench;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic cfg_we = 0, req_valid = 0, stat_rd = 0;
  logic [2:0] cfg_ch = 0, req_ch = 0;
  logic [1:0] cfg_sel = 0;
  logic [23:0] cfg_data = 0;
  logic [15:0] req_len = 0;
  logic [0:0] stat_ctl = 0;
  logic busy, done, flag_unsup, flag_err, mem_rd, mem_wr, mem_vfy, mem_wide;
  logic [15:0] done_cnt;
  logic [23:0] mem_addr;
  logic [7:0] stat_q;

  dma_xfer_seq u_dma_xfer_seq (.*);

  int errors = 0, checks = 0;
  string tag = "R4";
  bit comparing = 0;
  logic [47:0] q[$];

  int m_base_a[8], m_cur_a[8], m_base_c[8], m_cur_c[8], m_mode[8];
  bit m_mask[8], m_tc[8], m_rq[8];

  function automatic logic [47:0] ev(bit rd, bit wr, bit vf, bit wd, bit dn,
                                     bit un, bit er, int a, int c);
    return {1'b1, rd, wr, vf, wd, dn, un, er, a[23:0], c[15:0]};
  endfunction

  always @(posedge clk) begin
    #5;
    if (comparing) begin
      logic [47:0] exp_v, act_v;
      exp_v = (q.size() > 0) ? q.pop_front() : 48'd0;
      act_v = {busy, mem_rd, mem_wr, mem_vfy, mem_wide, done, flag_unsup, flag_err,
               mem_addr, done_cnt};
      checks++;
      if (act_v !== exp_v) begin
        errors++;
        $display("FAIL %s cycle compare: actual=%h expected=%h", tag, act_v, exp_v);
      end
    end
  end

  task automatic cfg(int ch, int sel, int data);
    @(negedge clk);
    cfg_we = 1; cfg_ch = ch[2:0]; cfg_sel = sel[1:0]; cfg_data = data[23:0];
    case (sel)
      0: begin m_base_a[ch] = data & 'hFFFFFF; m_cur_a[ch] = m_base_a[ch]; end
      1: begin m_base_c[ch] = data & 'hFFFF; m_cur_c[ch] = m_base_c[ch]; end
      2: m_mode[ch] = data & 'hFF;
      default: begin m_mask[ch] = data[0]; if (data[1]) m_rq[ch] = 1; end
    endcase
    @(negedge clk);
    cfg_we = 0;
  endtask

  function automatic void model(int ch, int len);
    int opm = (m_mode[ch] >> 6) & 3, typ = (m_mode[ch] >> 2) & 3;
    bit dec = m_mode[ch][5], au = m_mode[ch][4];
    if (m_mask[ch]) q.push_back(ev(0,0,0,0,1,0,0,0,0));
    else if (opm == 0 || opm == 2) q.push_back(ev(0,0,0,0,1,1,0,0,0));
    else if (opm == 3 || typ == 3) q.push_back(ev(0,0,0,0,1,0,1,0,0));
    else begin
      int n = (m_cur_c[ch] < len) ? m_cur_c[ch] : len;
      int sz = (ch >= 4) ? 2 : 1;
      for (int i = 0; i < n; i++) begin
        q.push_back(ev(typ == 2, typ == 1, typ == 0, ch >= 4, 0, 0, 0, m_cur_a[ch], 0));
        m_cur_a[ch] = (dec ? m_cur_a[ch] - sz : m_cur_a[ch] + sz) & 'hFFFFFF;
        m_cur_c[ch]--;
      end
      q.push_back(ev(0,0,0,0,1,0,0,0,n));
      if (m_cur_c[ch] == 0) begin
        m_tc[ch] = 1; m_rq[ch] = 0;
        if (au) begin m_cur_a[ch] = m_base_a[ch]; m_cur_c[ch] = m_base_c[ch]; end
      end
    end
  endfunction

  task automatic xfer(int ch, int len, string t, bit busy_wr = 0, int wsel = 0, int wdata = 0);
    @(negedge clk);
    tag = t;
    req_valid = 1; req_ch = ch[2:0]; req_len = len[15:0];
    model(ch, len);
    @(negedge clk);
    req_valid = 0;
    if (busy_wr) begin
      cfg_we = 1; cfg_ch = ch[2:0]; cfg_sel = wsel[1:0]; cfg_data = wdata[23:0];
      @(negedge clk);
      cfg_we = 0;
    end
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic status(int ctl, string t);
    logic [7:0] e;
    @(negedge clk);
    e = 0;
    for (int i = 0; i < 4; i++) begin e[i] = m_tc[ctl*4+i]; e[4+i] = m_rq[ctl*4+i]; end
    stat_rd = 1; stat_ctl = ctl[0:0];
    #1;
    checks++;
    if (stat_q !== e) begin
      errors++;
      $display("FAIL %s status ctl%0d: actual=%h expected=%h", t, ctl, stat_q, e);
    end
    for (int i = 0; i < 4; i++) m_tc[ctl*4+i] = 0;
    @(negedge clk);
    stat_rd = 0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_base_a[i] = 0; m_cur_a[i] = 0; m_base_c[i] = 0; m_cur_c[i] = 0;
      m_mode[i] = 0; m_mask[i] = 1; m_tc[i] = 0; m_rq[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    comparing = 1;
    status(0, "R9");
    status(1, "R9");
    xfer(0, 4, "R3");                          // R3 masked at reset
    // R1 R2 single mode, write to memory, increment, byte channel
    cfg(1, 0, 'h001000); cfg(1, 1, 5); cfg(1, 2, 'h44); cfg(1, 3, 2);
    status(0, "R10");
    xfer(1, 3, "R2");
    xfer(1, 10, "R4");                         // R4 min(count, len) = 2
    status(0, "R6");                            // R6 tc set, rq cleared
    status(0, "R9");                            // R9 cleared by read
    // R5 R7 read, decrement, autoinit, wide channel
    cfg(5, 0, 'h002000); cfg(5, 1, 3); cfg(5, 2, 'h78); cfg(5, 3, 0);
    xfer(5, 5, "R5");
    xfer(5, 2, "R7");
    status(1, "R6");
    // R7 verify without autoinit
    cfg(2, 0, 'h000300); cfg(2, 1, 2); cfg(2, 2, 'h40); cfg(2, 3, 0);
    xfer(2, 2, "R2");
    status(0, "R6");
    xfer(2, 2, "R7");
    status(0, "R7");
    // R8 illegal type and unsupported modes
    cfg(3, 1, 4); cfg(3, 3, 0);
    cfg(3, 2, 'h4C); xfer(3, 2, "R2");
    cfg(3, 2, 'hC4); xfer(3, 2, "R8");
    cfg(3, 2, 'h04); xfer(3, 2, "R8");
    cfg(3, 2, 'h84); xfer(3, 2, "R8");
    cfg(3, 2, 'h44); xfer(3, 2, "R1");
    // R3 masked request leaves state untouched
    cfg(1, 3, 1); xfer(1, 2, "R3");
    cfg(1, 3, 0); xfer(1, 2, "R3");
    // R10 write while busy ignored
    cfg(6, 0, 'h000500); cfg(6, 1, 6); cfg(6, 2, 'h48); cfg(6, 3, 0);
    xfer(6, 2, "R10", 1, 0, 'h00ABCD);
    xfer(6, 2, "R10");
    // R5 wrap on wide channel
    cfg(4, 0, 'hFFFFFF); cfg(4, 1, 3); cfg(4, 2, 'h48); cfg(4, 3, 0);
    xfer(4, 2, "R5");
    // R11 zero-length request
    xfer(4, 0, "R11");
    status(1, "R11");
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule